// File: doc/BRIEF.md
# DMA Protected Range Checker

This block guards a region of memory against device-initiated accesses. The protected window ends directly below a 1 MB-aligned segment base and extends downward by a programmable number of whole megabytes. Every DMA request reaches the block only after any address translation has been applied. A request that lands in the window is therefore faulted here even when the translation step accepted it.

A small configuration register holds the window size, an enable flag and a sticky lock flag. The same register reports a derived "protection active" status and the window's top address. The segment base arrives on an input bus; the register does not store it.

Requests arrive on a one-per-cycle valid/address interface, together with the blocking verdicts of other independent checkers. One cycle later the block returns whether the range check hit. It also returns the final verdict: a request is denied when any single source blocks it, and it is allowed only when every source passes.

Top module: `dpr_guard`

## Requirements
- R1: After reset, the configuration read value holds size 0, enable 0, status 0 and lock 0. Bits 31:20 still show the segment base. `rsp_valid`, `rsp_hit`, `rsp_deny` and `rsp_allow` are all 0.
- R2: While unlocked, a configuration write takes its fields from three places. The size in MB comes from data bits 11:4, the enable from bit 2 and the lock from bit 0. Read-back bits 19:12 and bit 3 are always 0.
- R3: Read-back bit 1 (status) is 1 exactly when the enable is 1 and the size is non-zero.
- R4: Once the lock bit reads 1, every later write leaves bits 11:0 unchanged until the next reset. A reset clears the lock.
- R5: Read-back bits 31:20 equal the low 12 bits of `seg_base_mb`. `top_addr` equals `seg_base_mb` multiplied by 1 MB, with address bits 19:0 zero.
- R6: With status 1, a request hits when its address lies in [top − size MB, top − 1]. Here top is `seg_base_mb` × 1 MB. An address of top, or of one byte below the window's low end, does not hit. When the size exceeds `seg_base_mb`, the low end is address 0.
- R7: With the enable at 0 or the size at 0, no request hits.
- R8: `rsp_deny` is the OR of the range hit and every bit of `ext_deny`. `rsp_allow` is 1 only for a valid response that is not denied.
- R9: Responses are registered. The result of a request presented with `req_valid` in one cycle appears in the next cycle. A cycle without a request gives `rsp_valid`, `rsp_hit`, `rsp_deny` and `rsp_allow` all 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Configuration read value |
| seg_base_mb | input | ADDR_W-20 | Segment base (window top) in MB units |
| top_addr | output | ADDR_W | Window top address (top − 1 is the last protected byte) |
| req_valid | input | 1 | DMA request present |
| req_addr | input | ADDR_W | Translated request address |
| ext_deny | input | N_EXT | Blocking verdicts of the other checkers |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Previous request fell inside the window |
| rsp_deny | output | 1 | Previous request is blocked |
| rsp_allow | output | 1 | Previous request may go to memory |

## Verification
The bench builds the block with its defaults: ADDR_W = 32, which gives a 12-bit segment base, and N_EXT = 3. With these values the segment base spans its whole 4 GB range. The random stimulus therefore reaches top values both below and above the 255 MB maximum size, and so exercises the clamp at address 0 as well as the plain subtraction. Three deny inputs are enough to show that each input blocks on its own, whether or not the range hits.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int SIZE_W    = 8;
  localparam int F_LOCK    = 0;
  localparam int F_STAT    = 1;
  localparam int F_EN      = 2;
  localparam int F_SIZE_LO = 4;
  localparam int F_TOP_LO  = 20;
  localparam int TOPF_W    = 32 - F_TOP_LO;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              en;
    logic              lock;
  } dpr_cfg_t;
endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dpr_cfg_reg.sv
module dpr_cfg_reg
  import dpr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output dpr_cfg_t    cfg_q
);
  dpr_cfg_t cfg_d;
  logic     upd;
  logic     unused_wr;

  // Reserved and read-only positions carry no state.
  assign unused_wr = ^{wr_data[31:F_SIZE_LO+SIZE_W], wr_data[3], wr_data[F_STAT]};

  always_comb begin
    upd   = wr_en & ~cfg_q.lock;
    cfg_d = cfg_q;
    if (upd) begin
      cfg_d.size = wr_data[F_SIZE_LO +: SIZE_W];
      cfg_d.en   = wr_data[F_EN];
      cfg_d.lock = wr_data[F_LOCK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg_q <= '0;
    else if (upd) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/dpr_window.sv
module dpr_window #(
  parameter int TOP_W  = 12,
  parameter int SIZE_W = 8
) (
  input  logic [TOP_W-1:0]  top_mb,
  input  logic [SIZE_W-1:0] size_mb,
  input  logic              active,
  input  logic [TOP_W-1:0]  addr_mb,
  output logic              hit
);
  localparam int EXT_W = ((TOP_W > SIZE_W) ? TOP_W : SIZE_W) + 1;

  logic [EXT_W-1:0] top_x;
  logic [EXT_W-1:0] size_x;
  logic [EXT_W-1:0] addr_x;
  logic [EXT_W-1:0] lo_x;
  logic             above_lo;
  logic             below_top;

  always_comb begin
    top_x     = EXT_W'(top_mb);
    size_x    = EXT_W'(size_mb);
    addr_x    = EXT_W'(addr_mb);
    // A window larger than the space below the top clamps at zero.
    lo_x      = (size_x > top_x) ? '0 : (top_x - size_x);
    above_lo  = (addr_x >= lo_x);
    below_top = (addr_x < top_x);
    hit       = active & above_lo & below_top;
  end
endmodule

// File: rtl/dpr_verdict.sv
module dpr_verdict #(
  parameter int N_EXT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             range_hit,
  input  logic [N_EXT-1:0] ext_deny,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_deny
);
  logic valid_d;
  logic hit_d;
  logic deny_d;

  always_comb begin
    valid_d = req_valid;
    hit_d   = req_valid & range_hit;
    deny_d  = req_valid & (range_hit | (|ext_deny));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_deny  <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_deny  <= deny_d;
    end
  end
endmodule

// File: rtl/dpr_guard.sv
module dpr_guard
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_EXT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wr_data,
  output logic [31:0]       cfg_rd_data,
  input  logic [ADDR_W-21:0] seg_base_mb,
  output logic [ADDR_W-1:0] top_addr,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N_EXT-1:0]  ext_deny,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_deny,
  output logic              rsp_allow
);
  localparam int TOP_W = ADDR_W - F_TOP_LO;

  logic              rst_sync_n;
  dpr_cfg_t          cfg;
  logic              active;
  logic              range_hit;
  logic [TOPF_W-1:0] top_field;
  logic              unused_addr_lo;

  assign unused_addr_lo = ^req_addr[F_TOP_LO-1:0];

  dpr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dpr_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_q   (cfg)
  );

  assign active = cfg.en & (|cfg.size);

  dpr_window #(.TOP_W(TOP_W), .SIZE_W(SIZE_W)) u_win (
    .top_mb  (seg_base_mb),
    .size_mb (cfg.size),
    .active  (active),
    .addr_mb (req_addr[ADDR_W-1:F_TOP_LO]),
    .hit     (range_hit)
  );

  dpr_verdict #(.N_EXT(N_EXT)) u_vrd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .range_hit (range_hit),
    .ext_deny  (ext_deny),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_deny  (rsp_deny)
  );

  assign rsp_allow = rsp_valid & ~rsp_deny;

  generate
    if (TOP_W >= TOPF_W) begin : g_top_trunc
      assign top_field = seg_base_mb[TOPF_W-1:0];
    end else begin : g_top_ext
      assign top_field = TOPF_W'(seg_base_mb);
    end
  endgenerate

  always_comb begin
    cfg_rd_data                         = '0;
    cfg_rd_data[F_LOCK]                 = cfg.lock;
    cfg_rd_data[F_STAT]                 = active;
    cfg_rd_data[F_EN]                   = cfg.en;
    cfg_rd_data[F_SIZE_LO +: SIZE_W]    = cfg.size;
    cfg_rd_data[F_TOP_LO +: TOPF_W]     = top_field;
  end

  assign top_addr = {seg_base_mb, {F_TOP_LO{1'b0}}};
endmodule

// File: rtl/dpr_guard_chk.sv
module dpr_guard_chk #(
  parameter int N_EXT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      cfg_rd_data,
  input logic             req_valid,
  input logic [N_EXT-1:0] ext_deny,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_deny,
  input logic             rsp_allow
);
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[0] |=> cfg_rd_data[0]);

  p_locked_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[0] |=> $stable(cfg_rd_data[11:0]));

  p_status_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[1] |-> (cfg_rd_data[2] && cfg_rd_data[11:4] != 8'h00));

  p_inactive_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd_data[1] |=> !rsp_hit);

  p_ext_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (|ext_deny)) |=> rsp_deny);

  p_hit_denied_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_deny);

  p_allow_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_allow |-> (rsp_valid && !rsp_deny));

  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_deny && !rsp_hit));
endmodule

bind dpr_guard dpr_guard_chk #(.N_EXT(N_EXT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cfg_rd_data (cfg_rd_data),
  .req_valid   (req_valid),
  .ext_deny    (ext_deny),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_deny    (rsp_deny),
  .rsp_allow   (rsp_allow)
);

// File: tb/dpr_guard_tb.sv
`timescale 1ns/1ps
module dpr_guard_tb;
  localparam int  ADDR_W = 32;
  localparam int  N_EXT  = 3;
  localparam int  TOP_W  = ADDR_W - 20;
  localparam time TCLK   = 20ns;

  logic              clk;
  logic              rst_n;
  logic              cfg_wr_en;
  logic [31:0]       cfg_wr_data;
  logic [31:0]       cfg_rd_data;
  logic [TOP_W-1:0]  seg_base_mb;
  logic [ADDR_W-1:0] top_addr;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [N_EXT-1:0]  ext_deny;
  logic              rsp_valid, rsp_hit, rsp_deny, rsp_allow;

  int n_chk;
  int n_bad;

  // bench-side model of the programmed state
  logic [7:0] m_size;
  logic       m_en;
  logic       m_lock;

  dpr_guard #(.ADDR_W(ADDR_W), .N_EXT(N_EXT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .seg_base_mb(seg_base_mb), .top_addr(top_addr),
    .req_valid(req_valid), .req_addr(req_addr), .ext_deny(ext_deny),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_deny(rsp_deny), .rsp_allow(rsp_allow)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  function automatic logic [31:0] exp_rd(logic [TOP_W-1:0] top, logic [7:0] sz, logic en, logic lk);
    return {top[11:0], 8'h00, sz, 1'b0, en, (en && sz != 8'h00), lk};
  endfunction

  function automatic logic exp_hit(logic [ADDR_W-1:0] a, logic [TOP_W-1:0] top, logic [7:0] sz, logic en);
    longint amb, lo;
    amb = longint'(a >> 20);
    lo  = (longint'(sz) > longint'(top)) ? 0 : longint'(top) - longint'(sz);
    return en && (sz != 0) && (amb >= lo) && (amb < longint'(top));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_size = 8'h00; m_en = 1'b0; m_lock = 1'b0;
  endtask

  task automatic cfg_write(logic [7:0] sz, logic en, logic lk);
    cfg_wr_data = {20'h00000, sz, 1'b0, en, 1'b0, lk};
    cfg_wr_en   = 1'b1;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
    if (!m_lock) begin m_size = sz; m_en = en; m_lock = lk; end
  endtask

  task automatic send(logic v, logic [ADDR_W-1:0] a, logic [N_EXT-1:0] ed, string req);
    logic h, d;
    h = v && exp_hit(a, seg_base_mb, m_size, m_en);
    d = v && (h || (ed != 0));
    req_valid = v; req_addr = a; ext_deny = ed;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " rsp"}, {60'h0, rsp_valid, rsp_hit, rsp_deny, rsp_allow},
          {60'h0, v, h, d, (v && !d)});
  endtask

  initial begin : wdog
    #(TCLK * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    n_chk = 0; n_bad = 0;
    void'($urandom(32'h5eed_0d9a));
    cfg_wr_en = 0; cfg_wr_data = 0; req_valid = 0; req_addr = 0; ext_deny = 0;
    seg_base_mb = 12'h100;
    do_reset();

    // R1 reset state
    check("R1 cfg", cfg_rd_data, exp_rd(12'h100, 8'h00, 1'b0, 1'b0));
    check("R1 rsp", {rsp_valid, rsp_hit, rsp_deny, rsp_allow}, 4'b0000);
    // R5 top reporting
    check("R5 top_addr", top_addr, 32'h1000_0000);

    // R2 / R3 program 16 MB enabled; reserved write bits set must read 0
    cfg_wr_data = 32'h000F_F10E | 32'h0000_000A; cfg_wr_en = 1; // size 0x10, bits 3,1 set
    @(negedge clk); cfg_wr_en = 0; m_size = 8'h10; m_en = 1; m_lock = 0;
    check("R2 cfg write", cfg_rd_data, exp_rd(12'h100, 8'h10, 1'b1, 1'b0));
    check("R3 status on", cfg_rd_data[1], 1'b1);

    // R6 boundaries: window 0x0F0_00000 .. 0x0FFF_FFFF
    send(1, 32'h0F00_0000, 0, "R6 low edge");
    send(1, 32'h0EFF_FFFF, 0, "R6 below low");
    send(1, 32'h0FFF_FFFF, 0, "R6 top-1");
    send(1, 32'h1000_0000, 0, "R6 at top");
    // R8 each external source alone, and with a hit
    send(1, 32'h0000_1000, 3'b001, "R8 ext0");
    send(1, 32'h0000_1000, 3'b010, "R8 ext1");
    send(1, 32'h0000_1000, 3'b100, "R8 ext2");
    send(1, 32'h0F80_0000, 3'b010, "R8 hit+ext");
    send(1, 32'h0000_1000, 3'b000, "R8 clean allow");
    // R9 idle cycle gives quiet response
    send(0, 32'h0F80_0000, 3'b111, "R9 idle");

    // R7 enable off, then size zero
    cfg_write(8'h10, 1'b0, 1'b0);
    check("R3 status en0", cfg_rd_data[1], 1'b0);
    send(1, 32'h0F80_0000, 0, "R7 en0");
    cfg_write(8'h00, 1'b1, 1'b0);
    check("R3 status size0", cfg_rd_data[1], 1'b0);
    send(1, 32'h0FF0_0000, 0, "R7 size0");

    // R6 clamp: top 5 MB, size 10 MB
    seg_base_mb = 12'h005;
    cfg_write(8'h0A, 1'b1, 1'b0);
    send(1, 32'h0000_0000, 0, "R6 clamp zero");
    send(1, 32'h004F_FFFF, 0, "R6 clamp top-1");
    send(1, 32'h0050_0000, 0, "R6 clamp at top");
    // R6 largest size
    seg_base_mb = 12'h200;
    cfg_write(8'hFF, 1'b1, 1'b0);
    check("R5 cfg top", cfg_rd_data[31:20], 12'h200);
    send(1, 32'h1010_0000, 0, "R6 max low edge");
    send(1, 32'h100F_FFFF, 0, "R6 max below");

    // randomised traffic with occasional reprogramming (lock kept clear)
    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      logic [N_EXT-1:0]  ed;
      int k;
      if ($urandom_range(0, 15) == 0) begin
        seg_base_mb = 12'($urandom);
        cfg_write(($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom), 1'($urandom_range(0, 4) != 0), 1'b0);
        check("R2 random cfg", cfg_rd_data, exp_rd(seg_base_mb, m_size, m_en, 1'b0));
      end
      k = $urandom_range(0, 3);
      if (k == 0) a = $urandom;
      else begin
        longint base;
        base = (k == 1) ? longint'(seg_base_mb) : longint'(seg_base_mb) - longint'(m_size);
        base = base + longint'($urandom_range(0, 4)) - 2;
        if (base < 0) base = 0;
        a = ADDR_W'(base << 20) | ADDR_W'(($urandom_range(0, 1) != 0) ? 32'h000F_FFFF : ($urandom & 32'h000F_FFFF));
      end
      ed = ($urandom_range(0, 3) == 0) ? N_EXT'($urandom) : '0;
      send(1'($urandom_range(0, 7) != 0), a, ed, "R6 R8 random");
    end

    // R4 lock, then attempt to rewrite
    seg_base_mb = 12'h040;
    cfg_write(8'h20, 1'b1, 1'b1);
    r = cfg_rd_data;
    check("R4 locked value", r, exp_rd(12'h040, 8'h20, 1'b1, 1'b1));
    cfg_write(8'h00, 1'b0, 1'b0);
    check("R4 write ignored", cfg_rd_data, r);
    cfg_write(8'h05, 1'b1, 1'b1);
    check("R4 write ignored 2", cfg_rd_data, r);
    send(1, 32'h03FF_FFFF, 0, "R4 still protecting");
    send(1, 32'h0200_0000, 0, "R4 low edge");
    do_reset();
    check("R4 reset unlocks", cfg_rd_data, exp_rd(12'h040, 8'h00, 1'b0, 1'b0));
    cfg_write(8'h03, 1'b1, 1'b0);
    check("R4 writable after reset", cfg_rd_data, exp_rd(12'h040, 8'h03, 1'b1, 1'b0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule